// File: doc/BRIEF.md
# PHY Management Interface Master

This block lets software run single clause-22 management transactions against an Ethernet PHY through four small word registers. Software first writes the target PHY address, register number and direction into the command register. For a write it also puts the 16-bit payload into the payload register. It then writes the control register with both the interface-enable bit and the go bit set.

The block drives the management clock (MDC) and shifts out one 64-bit frame on MDIO, most significant bit first:

- 32 preamble ones
- start bits `01`
- opcode: `10` for a read, `01` for a write
- five PHY address bits
- five register bits
- two turnaround bits
- 16 data bits

On a read the block releases the data line from the turnaround onwards. It samples the PHY on every rising MDC edge and keeps the 16 received bits in a read-back register. The go bit doubles as the busy indication. Software polls it until it drops.

MDC is the system clock divided by the even parameter `CLK_DIV`. MDC stays low whenever no frame is running.

Top module: `mdm_master`

Register map (`bus_addr`):

| Index | Register | Contents |
|-------|----------|----------|
| 0 | Command | bits 4:0 register number, bits 9:5 PHY address, bit 10 direction (1 read, 0 write) |
| 1 | Payload | 16-bit write data |
| 2 | Read-back | 16-bit read data, read-only |
| 3 | Control | bit 0 go/busy, bit 3 interface enable |

Register reads return data one cycle after the address is presented.

## Requirements
- R1: After reset the control, command and read-back registers read 0, MDC is low and the MDIO output enable is low.
- R2: The command register keeps only bits 10:0 (bits 4:0 register number, bits 9:5 PHY address, bit 10 direction with 1 = read). The payload register keeps bits 15:0. Unused bits read back as 0.
- R3: A control write with bit 0 set starts a frame only if bit 3 is also set in that same write. Bit 3 is stored and reads back in control bit 3. A go request with bit 3 clear leaves MDC idle and the status bit at 0.
- R4: Once a frame is accepted, control bit 0 reads 1 for exactly 64*CLK_DIV clock cycles and then reads 0.
- R5: A write frame on MDIO is 32 ones, `01`, `01`, PHY address, register number, `10`, then the payload, each field MSB first, with the output enable high for all 64 bits.
- R6: A read frame carries opcode `10`. The output enable drops for the last 18 bits (turnaround and data). The 16 bits sampled on the rising MDC edges of the data phase land in read-back bits 15:0.
- R7: MDC is low while idle. Each high phase lasts CLK_DIV/2 clock cycles, and every frame has exactly 64 rising edges.
- R8: The MDIO output and its enable change only while MDC is low.
- R9: A go request while a frame is running is ignored. The running frame keeps its content and its completion time.
- R10: The read-back register holds its value across write frames, and bus writes to it have no effect.
- R11: A go request presented on the clock edge at which a frame completes is ignored. The same request one cycle later starts a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register index (0 command, 1 payload, 2 read-back, 3 control) |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Registered read data of the addressed register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data driven toward MDIO |
| mdio_oe | output | 1 | Output enable for MDIO (0 = released) |
| mdio_i | input | 1 | Sampled MDIO line level |

## Verification
Frame completion and frame acceptance can meet in one clock edge. The edge that drops the busy bit and loads the read-back register can also be the one that sees a new go request. The bench counts cycles from acceptance and places a go write exactly on the completing edge, then again one edge later. It judges the first case by status reading 0 afterwards and no further MDC rising edges. It judges the second by status reading 1 on the next read and a complete, correct 64-bit frame following.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  // Frame geometry of a clause-22 management frame
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = 6;
  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int DATA_W     = 16;
  localparam int CMD_W      = 1 + PHY_AW + REG_AW;

  // Bit index (0 = first bit on the wire) where the line is released on reads
  localparam int TA_FIRST   = 46;
  // First bit index of the data phase
  localparam int DATA_FIRST = 48;

  // Control register bit positions
  localparam int CTRL_GO_BIT = 0;
  localparam int CTRL_EN_BIT = 3;

  typedef enum logic [1:0] {
    SEL_CMD   = 2'd0,
    SEL_WDATA = 2'd1,
    SEL_RDATA = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  // Packed in register layout: bit 10 direction, 9:5 PHY, 4:0 register
  typedef struct packed {
    logic              rd;
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
  } mgmt_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_cmd_t c, logic [DATA_W-1:0] d);
    return {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regad, 2'b10, d};
  endfunction

endpackage

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [1:0]          addr,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  input  logic                busy,
  input  logic                rd_done,
  input  logic [DATA_W-1:0]   rd_shift,
  output mgmt_cmd_t           cmd,
  output logic [DATA_W-1:0]   wr_word,
  output logic                go
);

  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] wr_q;
  logic [DATA_W-1:0] rd_q;
  logic              en_q;
  logic [BUS_W-1:0]  ctrl_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      if (we) begin
        case (reg_sel_e'(addr))
          SEL_CMD:   cmd_q <= wdata[CMD_W-1:0];
          SEL_WDATA: wr_q  <= wdata[DATA_W-1:0];
          SEL_CTRL:  en_q  <= wdata[CTRL_EN_BIT];
          default:   ;
        endcase
      end
      if (rd_done) rd_q <= rd_shift;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_GO_BIT] = busy;
    ctrl_view[CTRL_EN_BIT] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (reg_sel_e'(addr))
        SEL_CMD:   rdata <= BUS_W'(cmd_q);
        SEL_WDATA: rdata <= BUS_W'(wr_q);
        SEL_RDATA: rdata <= BUS_W'(rd_q);
        default:   rdata <= ctrl_view;
      endcase
    end
  end

  // A go request needs the enable bit in the same write
  assign go      = we && (reg_sel_e'(addr) == SEL_CTRL) && wdata[CTRL_GO_BIT] && wdata[CTRL_EN_BIT];
  assign cmd     = mgmt_cmd_t'(cmd_q);
  assign wr_word = wr_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_done |=> $stable(rd_q)); // R10

endmodule

// File: rtl/mdm_clkgen.sv
module mdm_clkgen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(HALF) + 1;

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign rise_stb = run && at_end && !mdc;
  assign fall_stb = run && at_end && mdc;

  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(mdc)) |-> ($past(cnt) == CW'(HALF - 1))); // R7

endmodule

// File: rtl/mdm_engine.sv
module mdm_engine
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  mgmt_cmd_t         cmd,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_shift
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W:0]   TA_IDX   = (IDX_W+1)'(TA_FIRST);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

  logic [FRAME_BITS-1:0] next_frame;
  logic [FRAME_BITS-2:0] shreg;
  logic [IDX_W-1:0]      bidx;
  logic [IDX_W:0]        bidx_nxt;
  logic                  is_rd;
  logic                  last_fall;

  assign next_frame = build_frame(cmd, cmd.rd ? {DATA_W{1'b1}} : wr_word);
  assign bidx_nxt   = {1'b0, bidx} + (IDX_W+1)'(1);
  assign last_fall  = busy && fall_stb && (bidx == LAST_IDX);
  assign rd_done    = last_fall && is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      shreg    <= '0;
      bidx     <= '0;
      is_rd    <= 1'b0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      rd_shift <= '0;
    end else if (!busy) begin
      if (go) begin
        busy    <= 1'b1;
        bidx    <= '0;
        is_rd   <= cmd.rd;
        shreg   <= next_frame[FRAME_BITS-2:0];
        mdio_o  <= next_frame[FRAME_BITS-1];
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_stb && is_rd && (bidx >= DAT_IDX))
        rd_shift <= {rd_shift[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (bidx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bidx    <= bidx_nxt[IDX_W-1:0];
          mdio_o  <= shreg[FRAME_BITS-2];
          shreg   <= {shreg[FRAME_BITS-3:0], 1'b0};
          mdio_oe <= !(is_rd && (bidx_nxt >= TA_IDX));
        end
      end
    end
  end

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && ({1'b0, bidx} >= TA_IDX)) |-> !mdio_oe); // R6

  AST_BUSY_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && go && !fall_stb) |=> (busy && $stable(bidx))); // R9

endmodule

// File: rtl/mdm_master.sv
module mdm_master
  import mdm_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int BUS_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  mgmt_cmd_t         cmd;
  logic [DATA_W-1:0] wr_word;
  logic [DATA_W-1:0] rd_shift;
  logic              go;
  logic              busy;
  logic              rd_done;
  logic              rise_stb;
  logic              fall_stb;

  mdm_regs #(.BUS_W(BUS_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .busy     (busy),
    .rd_done  (rd_done),
    .rd_shift (rd_shift),
    .cmd      (cmd),
    .wr_word  (wr_word),
    .go       (go)
  );

  mdm_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdm_engine u_engine (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .cmd      (cmd),
    .wr_word  (wr_word),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (rd_done),
    .rd_shift (rd_shift)
  );

  AST_MDIO_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc); // R8

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc); // R7

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_we && (bus_addr == 2'd3) && bus_wdata[CTRL_EN_BIT])); // R3

endmodule

// File: tb/sim_mdm_master.sv
module sim_mdm_master;

  localparam int CLK_PERIOD = 10;
  localparam int MDC_DIV    = 8;
  localparam int HALF       = MDC_DIV / 2;
  localparam int FRAME_CYC  = 64 * MDC_DIV;
  localparam int NVEC       = 6;

  // {rd, phy[4:0], reg[4:0], payload[15:0], phy reply[15:0]}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b0, 5'h01, 5'h00, 16'h1234, 16'h0000},
    {1'b1, 5'h01, 5'h01, 16'h0000, 16'h796D},
    {1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000},
    {1'b1, 5'h00, 5'h1F, 16'h0000, 16'h8001},
    {1'b0, 5'h15, 5'h0A, 16'h0000, 16'h0000},
    {1'b1, 5'h1F, 5'h00, 16'h0000, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, line;

  int checks = 0;
  int errors = 0;

  // PHY model state
  int          rises = 0;
  int          base  = 0;
  logic [63:0] cap   = '0;
  logic [63:0] oecap = '0;
  logic        phy_drv = 1'b0;
  logic        phy_bit = 1'b1;
  logic [15:0] phy_val = '0;

  int hi_run = 0, hi_err = 0, r8_err = 0;
  logic p_o = 1'b1, p_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  mdm_master #(.CLK_DIV(MDC_DIV), .BUS_W(16)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
  );

  always @(posedge mdc) begin
    int idx;
    idx = rises - base;
    if (idx >= 0 && idx < 64) begin
      cap[63-idx]   = line;
      oecap[63-idx] = mdio_oe;
    end
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    int idx;
    idx = rises - base;
    if (idx >= 47 && idx <= 63 && cap[29] && !cap[28]) begin
      phy_drv = 1'b1;
      phy_bit = (idx == 47) ? 1'b0 : phy_val[63-idx];
    end else begin
      phy_drv = 1'b0;
    end
  end

  // R7 high-phase width and R8 change-while-high monitors
  always @(negedge clk) begin
    if (rst) begin
      hi_run = 0;
    end else begin
      if (mdc) hi_run = hi_run + 1;
      else begin
        if (hi_run != 0 && hi_run != HALF) hi_err = hi_err + 1;
        hi_run = 0;
      end
      if (mdc && (mdio_o !== p_o || mdio_oe !== p_oe)) r8_err = r8_err + 1;
    end
    p_o  = mdio_o;
    p_oe = mdio_oe;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Start a frame, poll status every cycle; optional extra go on edge E0+k
  task automatic run_poll(input int again_edge, output int busy_cnt);
    bus_addr = 2'd3; bus_wdata = 16'h0009; bus_we = 1'b1;
    @(negedge clk);
    busy_cnt = 0;
    for (int k = 1; k < 4 * FRAME_CYC; k++) begin
      bus_we = (k == again_edge);
      @(negedge clk);
      if (bus_rdata[0]) busy_cnt++;
      else break;
    end
    bus_we = 1'b0;
  endtask

  function automatic logic [63:0] exp_frame(logic r, logic [4:0] p, logic [4:0] g, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g, 2'b10, d};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R4: watchdog expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] last_rd;
    int          cnt;
    logic [63:0] ef;
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 mdc", 64'(mdc), 64'd0);
    check("R1 oe", 64'(mdio_oe), 64'd0);
    rd(2'd3, v); check("R1 ctrl", 64'(v), 64'd0);
    rd(2'd0, v); check("R1 cmd", 64'(v), 64'd0);
    rd(2'd2, v); check("R1 rdata", 64'(v), 64'd0);
    last_rd = 16'h0;

    // R2 field widths
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R2 cmd", 64'(v), 64'h7FF);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); check("R2 wdata", 64'(v), 64'hFFFF);

    // R3 go without enable ignored, enable alone stored
    base = rises;
    wr(2'd3, 16'h0001); repeat (40) @(negedge clk);
    rd(2'd3, v); check("R3 go without enable", 64'(v), 64'd0);
    wr(2'd3, 16'h0008); repeat (40) @(negedge clk);
    rd(2'd3, v); check("R3 enable readback", 64'(v), 64'h8);
    check("R3 no mdc rises", 64'(rises - base), 64'd0);

    // Table of transactions: R4 R5 R6 R7 R10
    for (int i = 0; i < NVEC; i++) begin
      logic        r;
      logic [4:0]  p, g;
      logic [15:0] wd, pd;
      {r, p, g, wd, pd} = VEC[i];
      wr(2'd0, {5'b0, r, p, g});
      wr(2'd1, wd);
      phy_val = pd;
      base = rises;
      run_poll(-1, cnt);
      check("R4 busy cycles", 64'(cnt), 64'(FRAME_CYC));
      check("R7 rises per frame", 64'(rises - base), 64'd64);
      ef = exp_frame(r, p, g, r ? pd : wd);
      check(r ? "R6 read frame" : "R5 write frame", cap, ef);
      check(r ? "R6 oe pattern" : "R5 oe pattern", oecap,
            r ? {{46{1'b1}}, 18'b0} : {64{1'b1}});
      if (r) last_rd = pd;
      rd(2'd2, v);
      check(r ? "R6 captured data" : "R10 rdata held over write", 64'(v), 64'(last_rd));
    end

    // R10 writes to read-back ignored
    wr(2'd2, 16'hA5A5); rd(2'd2, v);
    check("R10 rdata write ignored", 64'(v), 64'(last_rd));

    // R9 go while busy ignored
    wr(2'd0, {5'b0, 1'b0, 5'h0C, 5'h03});
    wr(2'd1, 16'hC3A5);
    base = rises;
    run_poll(100, cnt);
    check("R9 completion time", 64'(cnt), 64'(FRAME_CYC));
    check("R9 frame content", cap, exp_frame(1'b0, 5'h0C, 5'h03, 16'hC3A5));
    repeat (20) @(negedge clk);
    check("R9 single frame", 64'(rises - base), 64'd64);

    // R11 go on the completing edge is ignored
    base = rises;
    run_poll(FRAME_CYC, cnt);
    check("R11 busy cycles", 64'(cnt), 64'(FRAME_CYC));
    repeat (20) @(negedge clk);
    rd(2'd3, v); check("R11 collision ignored status", 64'(v), 64'h8);
    check("R11 collision no new rises", 64'(rises - base), 64'd64);

    // R11 go one edge later is accepted
    base = rises;
    run_poll(FRAME_CYC + 1, cnt);
    base = rises;
    rd(2'd3, v); check("R11 next edge accepted", 64'(v), 64'h9);
    for (int w = 0; w < 4 * FRAME_CYC; w++) begin
      rd(2'd3, v);
      if (!v[0]) break;
    end
    check("R11 second frame rises", 64'(rises - base), 64'd64);
    check("R11 second frame content", cap, exp_frame(1'b0, 5'h0C, 5'h03, 16'hC3A5));

    check("R7 high phase width", 64'(hi_err), 64'd0);
    check("R7 idle low", 64'(mdc), 64'd0);
    check("R8 mdio stable while mdc high", 64'(r8_err), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule